// File: doc/BRIEF.md
# Accumulator Core with Branch Delay Slot

This block is a small 8-bit processor with separate program and data spaces. It reads 16-bit instruction words from an external program ROM and works on an external byte-wide data RAM. Its only state is an accumulator, a page register, a program counter and one instruction register. The upper byte of an instruction word selects the operation. The lower byte is either an immediate value or a RAM offset.

Fetch and execute overlap in a two-stage pipeline. While one instruction executes, the next one is already being fetched. A branch therefore redirects the program counter only after the following word is in flight, and that word, the delay slot, always executes. Software can put useful work in the slot, for example shifting the accumulator during a loop back. A branch to its own address together with its slot makes a tight endless loop.

Both memories are read combinationally in the same cycle as the address. RAM writes happen on the clock edge that ends the store.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `rom_addr` is 0 and `ram_we` is 0. After reset the accumulator and page register are 0, and the first instruction executed is the one at ROM address 0.
- R2: Opcode 0x00 loads the operand byte into the accumulator. Opcode 0x01 loads the accumulator from RAM address {0x00, operand}.
- R3: Opcode 0x69 XORs the accumulator with RAM[{page, operand}]. Opcode 0x61 XORs it with RAM[{0x00, operand}]. Opcode 0x82 doubles the accumulator, modulo 256.
- R4: Opcode 0xC2 writes the accumulator to RAM[{0x00, operand}]. Opcode 0xCA writes it to RAM[{page, operand}]. Opcode 0xD6 writes it to RAM[{0x00, operand}] and also copies it into the page register. No other opcode changes the page register.
- R5: Opcode 0xFC always branches. The new program counter keeps the upper bits of the delay-slot instruction's address and takes the operand as its low byte, so a branch at 0x0FF lands in page 0x01.
- R6: The instruction right after a branch executes whether or not the branch is taken. When the branch is taken, the instruction after that slot does not execute.
- R7: Opcode 0xF0 branches only when the accumulator is zero. Opcode 0xEC branches only when it is non-zero.
- R8: A conditional branch tests the accumulator as it stands when the branch executes, not the value its delay slot produces.
- R9: Any other opcode changes no state and writes no RAM, and the program counter advances by one past it.
- R10: A branch to its own address with a non-branch in its slot loops forever. The fetch address alternates between the branch and its slot on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | PC_W | Program counter, address of the word being fetched |
| rom_data | input | 16 | Instruction word at `rom_addr`, same cycle |
| ram_addr | output | 16 | Data address of the executing instruction |
| ram_rdata | input | 8 | RAM byte at `ram_addr`, same cycle |
| ram_wdata | output | 8 | Byte to write, always the accumulator |
| ram_we | output | 1 | Write strobe, taken at the next rising edge |

## Verification
The program counter is visible at `rom_addr` on every cycle. A wrong branch decision, a wrong target page or a missing delay slot therefore shows up at the fetch address one cycle after the branch executes. A wrong accumulator or page register cannot be seen directly. It only appears when a later store puts a wrong byte or a wrong address on the RAM port. Each directed program ends by storing its results, and RAM is checked after the program settles into a self-loop. Skipped instructions are stores, so a missing delay slot or an executed skipped instruction leaves a visible mark in RAM.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int PC_W = 16,
  parameter logic [15:0] NOP_WORD = 16'h0200
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] rom_addr,
  input  logic [15:0]     rom_data,
  output logic [15:0]     ram_addr,
  input  logic [7:0]      ram_rdata,
  output logic [7:0]      ram_wdata,
  output logic            ram_we
);
  localparam logic [7:0] OP_LDI  = 8'h00;
  localparam logic [7:0] OP_LDM  = 8'h01;
  localparam logic [7:0] OP_XORY = 8'h69;
  localparam logic [7:0] OP_XORZ = 8'h61;
  localparam logic [7:0] OP_DBL  = 8'h82;
  localparam logic [7:0] OP_STZ  = 8'hC2;
  localparam logic [7:0] OP_STY  = 8'hCA;
  localparam logic [7:0] OP_STPG = 8'hD6;
  localparam logic [7:0] OP_JMP  = 8'hFC;
  localparam logic [7:0] OP_JZ   = 8'hF0;
  localparam logic [7:0] OP_JNZ  = 8'hEC;

  logic [PC_W-1:0] pc;
  logic [15:0]     ir;
  logic [7:0]      ac, pg, ac_nx;
  logic [7:0]      op, arg;
  logic            taken;

  assign op  = ir[15:8];
  assign arg = ir[7:0];

  assign rom_addr  = pc;
  assign ram_addr  = (op == OP_XORY || op == OP_STY) ? {pg, arg} : {8'h00, arg};
  assign ram_wdata = ac;
  assign ram_we    = (op == OP_STZ) || (op == OP_STY) || (op == OP_STPG);

  assign taken = (op == OP_JMP) ||
                 (op == OP_JZ  && ac == 8'h00) ||
                 (op == OP_JNZ && ac != 8'h00);

  always_comb begin
    case (op)
      OP_LDI:           ac_nx = arg;
      OP_LDM:           ac_nx = ram_rdata;
      OP_XORY, OP_XORZ: ac_nx = ac ^ ram_rdata;
      OP_DBL:           ac_nx = ac + ac;
      default:          ac_nx = ac;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= NOP_WORD;
      ac <= 8'h00;
      pg <= 8'h00;
    end else begin
      ir <= rom_data;
      pc <= taken ? {pc[PC_W-1:8], arg} : pc + 1'b1;
      ac <= ac_nx;
      if (op == OP_STPG) pg <= ac;
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input logic [15:0]     ir,
  input logic [7:0]      ac,
  input logic [7:0]      pg,
  input logic            ram_we
);
  logic is_br;
  assign is_br = (ir[15:8] == 8'hFC) || (ir[15:8] == 8'hF0) || (ir[15:8] == 8'hEC);

  always @(posedge clk)
    if (!rst_n) AST_RESET_IDLE: assert (pc == '0 && !ram_we); // R1

  AST_BRA_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[15:8] == 8'hFC) |=> (pc == {$past(pc[PC_W-1:8]), $past(ir[7:0])})); // R5

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_br |=> (pc == $past(pc) + 1'b1)); // R9

  AST_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[15:8] == 8'h82) |=> (ac == 8'($past(ac) << 1))); // R3

  AST_PAGE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[15:8] == 8'hD6) |=> (pg == $past(ac))); // R4

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[15:8] != 8'hD6) |=> $stable(pg)); // R4
endmodule

bind acc_core acc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .ir(ir), .ac(ac), .pg(pg), .ram_we(ram_we)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rom_addr;
  logic [15:0] rom_data;
  logic [15:0] ram_addr;
  logic [7:0]  ram_rdata;
  logic [7:0]  ram_wdata;
  logic        ram_we;

  logic [15:0] rom [512];
  logic [7:0]  ram [4096];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  assign rom_data  = rom[rom_addr[8:0]];
  assign ram_rdata = ram[ram_addr[11:0]];
  always @(posedge clk) if (ram_we) ram[ram_addr[11:0]] <= ram_wdata;

  acc_core u0 (.clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
               .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
               .ram_we(ram_we));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 512; i++) rom[i] = 16'h0200;
    for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
  endtask

  task automatic go(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    setup();
    ram[12'h0A0] = 8'hFF; ram[12'h0A1] = 8'hFF;
    rom[0] = 16'hC2A0; rom[1] = 16'hCAA1; rom[2] = 16'hFC02; rom[3] = 16'h0200;
    @(negedge clk);
    chk("R1 rom_addr in reset", rom_addr, 0);
    chk("R1 ram_we in reset", ram_we, 0);
    go(20);
    chk("R1 accumulator zero", ram[12'h0A0], 8'h00);
    chk("R1 page zero", ram[12'h0A1], 8'h00);
  endtask

  task automatic t_load_store();
    setup();
    rom[0] = 16'h005A; rom[1] = 16'hC210; rom[2] = 16'h00FF; rom[3] = 16'h0110;
    rom[4] = 16'h8200; rom[5] = 16'hC211; rom[6] = 16'h0003; rom[7] = 16'hD612;
    rom[8] = 16'h0077; rom[9] = 16'hCA20; rom[10] = 16'hFC0A; rom[11] = 16'h0200;
    go(30);
    chk("R2 load immediate", ram[12'h010], 8'h5A);
    chk("R2 load from RAM then R3 double", ram[12'h011], 8'hB4);
    chk("R4 store with page copy", ram[12'h012], 8'h03);
    chk("R4 paged store", ram[12'h320], 8'h77);
    chk("R4 paged store not in page 0", ram[12'h020], 8'h00);
  endtask

  task automatic t_xor();
    setup();
    ram[12'h030] = 8'h0F; ram[12'h230] = 8'hF0;
    rom[0] = 16'h0002; rom[1] = 16'hD640; rom[2] = 16'h00FF; rom[3] = 16'h6130;
    rom[4] = 16'hC241; rom[5] = 16'h6930; rom[6] = 16'hC242; rom[7] = 16'hFC07;
    go(30);
    chk("R3 xor page zero", ram[12'h041], 8'hF0);
    chk("R3 xor paged", ram[12'h042], 8'h00);
  endtask

  task automatic t_slot();
    setup();
    rom[0] = 16'h0001; rom[1] = 16'hFC05; rom[2] = 16'h8200; rom[3] = 16'h0099;
    rom[4] = 16'hC250; rom[5] = 16'hC251; rom[6] = 16'hFC06;
    go(30);
    chk("R6 delay slot executed", ram[12'h051], 8'h02);
    chk("R6 skipped store absent", ram[12'h050], 8'h00);
  endtask

  task automatic t_jz();
    setup();
    rom[0] = 16'h0000; rom[1] = 16'hF005; rom[2] = 16'h0007; rom[3] = 16'h00EE;
    rom[4] = 16'hC260; rom[5] = 16'hC261; rom[6] = 16'hF00A; rom[7] = 16'h0000;
    rom[8] = 16'h0033; rom[9] = 16'hC262; rom[10] = 16'hFC0A;
    go(30);
    chk("R7 zero branch taken, slot ran", ram[12'h061], 8'h07);
    chk("R7 zero branch skip", ram[12'h060], 8'h00);
    chk("R8 condition before slot", ram[12'h062], 8'h33);
  endtask

  task automatic t_jnz();
    setup();
    rom[0] = 16'h0004; rom[1] = 16'hEC05; rom[2] = 16'h8200; rom[3] = 16'h0000;
    rom[4] = 16'hC270; rom[5] = 16'hC271; rom[6] = 16'h0000; rom[7] = 16'hEC0C;
    rom[8] = 16'h00AA; rom[9] = 16'hC272; rom[10] = 16'hFC0A;
    go(30);
    chk("R7 nonzero branch taken", ram[12'h071], 8'h08);
    chk("R7 nonzero branch skip", ram[12'h070], 8'h00);
    chk("R7 nonzero branch not taken", ram[12'h072], 8'hAA);
  endtask

  task automatic t_nop();
    setup();
    rom[0] = 16'h0011; rom[1] = 16'h1234; rom[2] = 16'h3F00; rom[3] = 16'hC280;
    rom[4] = 16'hFC04;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R9 pc steps over unknown opcode", rom_addr, 3);
    repeat (20) @(negedge clk);
    chk("R9 unknown opcodes keep AC", ram[12'h080], 8'h11);
    chk("R9 unknown opcode writes nothing", ram[12'h034], 8'h00);
  endtask

  task automatic t_selfloop();
    setup();
    rom[0] = 16'h0005; rom[1] = 16'hFC01; rom[2] = 16'h8200;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 2; k < 12; k++) begin
      @(negedge clk);
      chk("R10 self loop fetch", rom_addr, (k % 2 == 0) ? 2 : 1);
    end
  endtask

  task automatic t_page();
    setup();
    rom[0] = 16'hFCFF; rom[9'h0FF] = 16'hFC10; rom[9'h100] = 16'h0042;
    rom[9'h110] = 16'hC290; rom[9'h111] = 16'hFC11;
    rom[9'h010] = 16'hC291; rom[9'h011] = 16'hFC11;
    go(30);
    chk("R5 target in delay-slot page", ram[12'h090], 8'h42);
    chk("R5 not in branch page", ram[12'h091], 8'h00);
    chk("R5 loop stays in page 1", {7'd0, rom_addr[8]}, 1);
  endtask

  initial begin
    t_reset();
    t_load_store();
    t_xor();
    t_slot();
    t_jz();
    t_jnz();
    t_nop();
    t_selfloop();
    t_page();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule